// File: doc/BRIEF.md
# Shared-Pin GPIO Port with PWM and SPI Ownership

This block is an 8-bit general-purpose I/O port. Its pins are shared with an 8-channel PWM unit and two SPI controllers. Each pin has a fixed ownership priority: an enabled PWM channel comes first, then an enabled SPI controller, and then plain GPIO. The block drives every pad's output value and output enable from the function that owns that pin.

Software reaches three registers through a simple synchronous write, combinational read bus:
- the output data latch, at address 0;
- a read-only view of the synchronized pins, at address 1;
- the direction register, at address 2.

Every pad input passes through a two-flop synchronizer. The synchronized value feeds the input view, the direction-dependent data read and the peripherals' receive signals.

The block carries no streaming data, so there is no valid/ready handshake and no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. A read returns its value in the same cycle.

Pin roles for the shared functions:
- The second SPI controller uses pins 7..4 for SCK, SS, MOSI and MISO, in that order.
- The first SPI controller uses pins 3..0 for SS, SCK, MOSI and MISO, in that order.
- PWM channel n uses pin n.

Top module: `gpio_mux_port`

## Requirements
- R1: While `rst_n` is low, reads at addresses 0, 1 and 2 all return 0x00, and `pin_oe` is 0x00 (with no PWM or SPI enabled).
- R2: Writes to address 0 (data) and address 2 (direction) take effect on the clock edge where `bus_wr` is high. Reading address 2 returns the direction value. Reading address 0 with all direction bits at 1 returns the data value.
- R3: A read at address 0 returns, for each bit, the data latch where the direction bit is 1 and the synchronized pin where it is 0.
- R4: Address 1 always returns the synchronized pins, whatever function owns them. A write to address 1 changes neither the data nor the direction register.
- R5: A change on `pin_in` that is present before clock edge k appears at address 1 and on `periph_in` after edge k+1, and not after edge k alone. This also holds for the first two edges after reset is released.
- R6: A pin whose PWM channel is enabled drives `pin_out` = `pwm_out[n]` with `pin_oe` = 1, whatever the SPI or GPIO settings are (except as R7 states).
- R7: When `pwm_ch7_shutdown` is 1 and channel 7 is enabled, pin 7 is an input: `pin_oe[7]` = 0 and `pin_out[7]` = 0.
- R8: A pin without an enabled PWM channel takes `pin_out` and `pin_oe` from its SPI controller when that controller is enabled. `spi1_*[i]` maps to pin i, and `spi2_*[i]` maps to pin i+4.
- R9: A pin owned by neither PWM nor SPI drives the data latch bit, with `pin_oe` equal to the direction bit.
- R10: A read at address 3 returns 0x00, and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 pin view, 2 direction |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pwm_en | input | 8 | Per-channel PWM enable |
| pwm_out | input | 8 | Per-channel PWM waveform |
| pwm_ch7_shutdown | input | 1 | Turns pin 7 into an input while channel 7 is enabled |
| spi1_en | input | 1 | First SPI controller enable |
| spi1_out | input | 4 | First SPI pin values, bit i for pin i |
| spi1_oe | input | 4 | First SPI output enables, bit i for pin i |
| spi2_en | input | 1 | Second SPI controller enable |
| spi2_out | input | 4 | Second SPI pin values, bit i for pin i+4 |
| spi2_oe | input | 4 | Second SPI output enables, bit i for pin i+4 |
| pin_in | input | 8 | Raw pad inputs |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| periph_in | output | 8 | Synchronized pad values for the peripherals |

## Verification
The hardest case to reach is the ownership decision across every mix of PWM enables, SPI enables and the channel-7 shutdown on top of a fixed GPIO setting. The bench sweeps all 256 PWM enable masks against all eight SPI/shutdown combinations. It does this under two different sets of data, direction and peripheral drive patterns, and computes each pin's expected owner arithmetically. The synchronizer edge, including the two edges right after reset release, is reached by holding the pins at a known value through reset and then reading the input view once after each edge.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int PORT_W    = 8;
  localparam int SPI_PINS  = 4;
  localparam int ADDR_W    = 2;
  localparam int SYNC_LEN  = 2;

  typedef logic [PORT_W-1:0] port_t;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_PINS = 2'd1,
    REG_DIR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
  import gpio_mux_pkg::*;
#(
  parameter int W      = PORT_W,
  parameter int STAGES = SYNC_LEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];

  // cycles since reset release, saturating; used only to bound the latency check
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_lat2
      // R5: output equals the input seen two edges earlier
      a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (q == $past(d, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  port_t             wdata,
  input  port_t             pins_sync,
  output port_t             rdata,
  output port_t             data_q,
  output port_t             dir_q
);
  reg_sel_t sel;
  assign sel = reg_sel_t'(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr) begin
      case (sel)
        REG_DATA: data_q <= wdata;
        REG_DIR:  dir_q  <= wdata;
        default:  ;
      endcase
    end
  end

  port_t data_view;
  assign data_view = (dir_q & data_q) | (~dir_q & pins_sync);

  always_comb begin
    case (sel)
      REG_DATA: rdata = data_view;
      REG_PINS: rdata = pins_sync;
      REG_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end

  a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_DATA) |=> (data_q == $past(wdata)));
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_DIR) |=> (dir_q == $past(wdata)));
  a_r4_pin_view_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_PINS) |=> ($stable(data_q) && $stable(dir_q)));
  a_r10_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_NONE) |=> ($stable(data_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pin_owner.sv
module gpio_pin_owner
  import gpio_mux_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  port_t               pwm_en,
  input  port_t               pwm_out,
  input  logic                pwm_ch7_shutdown,
  input  logic                spi1_en,
  input  logic [SPI_PINS-1:0] spi1_out,
  input  logic [SPI_PINS-1:0] spi1_oe,
  input  logic                spi2_en,
  input  logic [SPI_PINS-1:0] spi2_out,
  input  logic [SPI_PINS-1:0] spi2_oe,
  input  port_t               data_q,
  input  port_t               dir_q,
  output port_t               pin_out,
  output port_t               pin_oe
);
  localparam int LAST = PORT_W - 1;

  genvar i;
  generate
    for (i = 0; i < PORT_W; i++) begin : g_pin
      logic spi_on, spi_o, spi_e;
      if (i < SPI_PINS) begin : g_spi1
        assign spi_on = spi1_en;
        assign spi_o  = spi1_out[i];
        assign spi_e  = spi1_oe[i];
      end else begin : g_spi2
        assign spi_on = spi2_en;
        assign spi_o  = spi2_out[i-SPI_PINS];
        assign spi_e  = spi2_oe[i-SPI_PINS];
      end

      logic pwm_input;
      if (i == LAST) begin : g_shut
        assign pwm_input = pwm_ch7_shutdown;
      end else begin : g_noshut
        assign pwm_input = 1'b0;
      end

      always_comb begin
        if (pwm_en[i]) begin
          pin_oe[i]  = ~pwm_input;
          pin_out[i] = pwm_input ? 1'b0 : pwm_out[i];
        end else if (spi_on) begin
          pin_oe[i]  = spi_e;
          pin_out[i] = spi_o;
        end else begin
          pin_oe[i]  = dir_q[i];
          pin_out[i] = data_q[i];
        end
      end

      if (i != LAST) begin : g_chk
        // R6: an enabled PWM channel always drives its pin
        a_r6_pwm_wins: assert property (@(posedge clk) disable iff (!rst_n)
          pwm_en[i] |-> (pin_oe[i] && pin_out[i] == pwm_out[i]));
      end
    end
  endgenerate

  a_r7_shutdown_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en[LAST] && pwm_ch7_shutdown) |-> (!pin_oe[LAST] && !pin_out[LAST]));
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  pwm_en,
  input  logic [7:0]  pwm_out,
  input  logic        pwm_ch7_shutdown,
  input  logic        spi1_en,
  input  logic [3:0]  spi1_out,
  input  logic [3:0]  spi1_oe,
  input  logic        spi2_en,
  input  logic [3:0]  spi2_out,
  input  logic [3:0]  spi2_oe,
  input  logic [7:0]  pin_in,
  output logic [7:0]  pin_out,
  output logic [7:0]  pin_oe,
  output logic [7:0]  periph_in
);
  port_t pins_sync, data_q, dir_q;

  gpio_pin_sync #(.W(PORT_W), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  gpio_port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .pins_sync(pins_sync), .rdata(bus_rdata),
    .data_q(data_q), .dir_q(dir_q)
  );

  gpio_pin_owner u_owner (
    .clk(clk), .rst_n(rst_n),
    .pwm_en(pwm_en), .pwm_out(pwm_out), .pwm_ch7_shutdown(pwm_ch7_shutdown),
    .spi1_en(spi1_en), .spi1_out(spi1_out), .spi1_oe(spi1_oe),
    .spi2_en(spi2_en), .spi2_out(spi2_out), .spi2_oe(spi2_oe),
    .data_q(data_q), .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign periph_in = pins_sync;

  // R4: the pin view and the peripheral feed never disagree
  a_r4_view_matches_periph: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata == periph_in));
  // R9: a pin with no peripheral owner follows the direction register
  a_r9_gpio_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en == 8'h00 && !spi1_en && !spi2_en) |-> (pin_oe == dir_q));
endmodule

// File: tb/gpio_mux_port_test.sv
`timescale 1ns/1ps
module gpio_mux_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pwm_en = '0, pwm_out = '0;
  logic       pwm_ch7_shutdown = 1'b0;
  logic       spi1_en = 1'b0, spi2_en = 1'b0;
  logic [3:0] spi1_out = '0, spi1_oe = '0, spi2_out = '0, spi2_oe = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, periph_in;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_mux_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_en(pwm_en),
    .pwm_out(pwm_out), .pwm_ch7_shutdown(pwm_ch7_shutdown),
    .spi1_en(spi1_en), .spi1_out(spi1_out), .spi1_oe(spi1_oe),
    .spi2_en(spi2_en), .spi2_out(spi2_out), .spi2_oe(spi2_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .periph_in(periph_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic void own_model(
    input logic [7:0] data, input logic [7:0] dir, input logic [7:0] pe,
    input logic [7:0] po, input logic sd, input logic s1, input logic [3:0] s1o,
    input logic [3:0] s1e, input logic s2, input logic [3:0] s2o, input logic [3:0] s2e,
    output logic [7:0] eo, output logic [7:0] ee);
    for (int i = 0; i < 8; i++) begin
      logic son, so, se;
      son = (i < 4) ? s1 : s2;
      so  = (i < 4) ? s1o[i % 4] : s2o[i % 4];
      se  = (i < 4) ? s1e[i % 4] : s2e[i % 4];
      if (pe[i]) begin
        if (i == 7 && sd) begin ee[i] = 1'b0; eo[i] = 1'b0; end
        else begin ee[i] = 1'b1; eo[i] = po[i]; end
      end else if (son) begin
        ee[i] = se; eo[i] = so;
      end else begin
        ee[i] = dir[i]; eo[i] = data[i];
      end
    end
  endfunction

  task automatic own_sweep(input logic [7:0] data, input logic [7:0] dir,
                           input logic [7:0] po, input logic [3:0] s1o, input logic [3:0] s1e,
                           input logic [3:0] s2o, input logic [3:0] s2e);
    logic [7:0] eo, ee;
    wr(2'd0, data);
    wr(2'd2, dir);
    pwm_out = po; spi1_out = s1o; spi1_oe = s1e; spi2_out = s2o; spi2_oe = s2e;
    for (int m = 0; m < 256; m++) begin
      for (int c = 0; c < 8; c++) begin
        pwm_en = m[7:0];
        spi1_en = c[0]; spi2_en = c[1]; pwm_ch7_shutdown = c[2];
        #1;
        own_model(data, dir, m[7:0], po, c[2], c[0], s1o, s1e, c[1], s2o, s2e, eo, ee);
        check("R6/R7/R8/R9 pin_out", pin_out, eo);
        check("R6/R7/R8/R9 pin_oe", pin_oe, ee);
      end
    end
    pwm_en = '0; spi1_en = 1'b0; spi2_en = 1'b0; pwm_ch7_shutdown = 1'b0;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] dirs [5];
    logic [7:0] pats [4];
    dirs[0] = 8'h00; dirs[1] = 8'hFF; dirs[2] = 8'h0F; dirs[3] = 8'hA5; dirs[4] = 8'h3C;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h69; pats[3] = 8'hC3;

    // R1: reset state with pins held high
    pin_in = 8'hFF;
    tick(); tick(); tick();
    rd(2'd0, v); check("R1 data read in reset", v, 8'h00);
    rd(2'd1, v); check("R1 pin view in reset", v, 8'h00);
    rd(2'd2, v); check("R1 dir in reset", v, 8'h00);
    check("R1 pin_oe in reset", pin_oe, 8'h00);

    // R5: first two edges after release
    rst_n = 1'b1;
    tick();
    rd(2'd1, v); check("R5 one edge after release", v, 8'h00);
    check("R5 periph one edge", periph_in, 8'h00);
    tick();
    rd(2'd1, v); check("R5 two edges after release", v, 8'hFF);
    check("R5 periph two edges", periph_in, 8'hFF);

    // R2: direction and data write/readback sweep
    for (int d = 0; d < 256; d++) begin
      wr(2'd2, d[7:0]);
      rd(2'd2, v); check("R2 dir readback", v, d[7:0]);
    end
    wr(2'd2, 8'hFF);
    for (int d = 0; d < 256; d++) begin
      wr(2'd0, d[7:0]);
      rd(2'd0, v); check("R2 data readback", v, d[7:0]);
    end

    // R3: per-bit direction-dependent data read
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 4; p++) begin
          wr(2'd2, dirs[a]);
          wr(2'd0, pats[b]);
          pin_in = pats[p] ^ 8'h5A;
          tick(); tick();
          rd(2'd0, v);
          check("R3 mixed data read", v, (dirs[a] & pats[b]) | (~dirs[a] & (pats[p] ^ 8'h5A)));
          // R4: pin view ignores ownership and direction
          rd(2'd1, v); check("R4 pin view", v, pats[p] ^ 8'h5A);
        end

    // R4: writes to the pin view change nothing
    wr(2'd0, 8'h3C); wr(2'd2, 8'hC3);
    pin_in = 8'h81; tick(); tick();
    wr(2'd1, 8'hE7);
    rd(2'd2, v); check("R4 dir after pin-view write", v, 8'hC3);
    wr(2'd2, 8'hFF);
    rd(2'd0, v); check("R4 data after pin-view write", v, 8'h3C);
    rd(2'd1, v); check("R4 pin view after write", v, 8'h81);

    // R4: pin view under PWM ownership still shows the pad
    pwm_en = 8'hFF; pwm_out = 8'h00; pin_in = 8'h5A; tick(); tick();
    rd(2'd1, v); check("R4 view while PWM owns", v, 8'h5A);
    pwm_en = 8'h00;

    // R5: latency of a mid-run pin change
    pin_in = 8'h24; tick(); tick();
    pin_in = 8'hDB; tick();
    rd(2'd1, v); check("R5 one edge after change", v, 8'h24);
    check("R5 periph one edge after change", periph_in, 8'h24);
    tick();
    rd(2'd1, v); check("R5 two edges after change", v, 8'hDB);
    check("R5 periph two edges after change", periph_in, 8'hDB);

    // R10: unmapped address
    wr(2'd0, 8'h96); wr(2'd2, 8'h69);
    rd(2'd3, v); check("R10 hole read", v, 8'h00);
    wr(2'd3, 8'h11);
    rd(2'd2, v); check("R10 dir after hole write", v, 8'h69);
    wr(2'd2, 8'hFF);
    rd(2'd0, v); check("R10 data after hole write", v, 8'h96);
    rd(2'd3, v); check("R10 hole read again", v, 8'h00);

    // R6 R7 R8 R9: ownership sweeps
    own_sweep(8'h5A, 8'hC3, 8'h96, 4'hA, 4'h6, 4'h3, 4'h9);
    own_sweep(8'hA5, 8'h3C, 8'h69, 4'h5, 4'h9, 4'hC, 4'h6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule